// File: doc/BRIEF.md
# Atomic Buffer-List Push/Pop Engine

This block keeps several independent last-in-first-out lists of buffer addresses, the kind used to hand out and reclaim free packet buffers. The list links live in an internal word-addressed RAM: each buffer address doubles as the RAM word that holds the address of the next buffer in its list. The head of every list sits in a register inside the controller. A head value of zero means the list is empty.

Two requesters issue commands over a valid/ready handshake. A push names a list and carries two operands. Their sum is the buffer address to link in. A pop names a list and gets back the current head, or an empty indication. The engine runs one command at a time, so every push and pop is atomic against the other requester. A requester holds `valid` and its command fields steady until it sees `ready` at a clock edge. That edge is the acceptance. While a command runs, both `ready` outputs are low, so each requester waits. Every command ends with a one-cycle `done` pulse that carries the result and the index of the requester that issued it.

Top module: `buflist_engine`

## Requirements
- R1: After reset, every list is empty and `done` is low. A pop from any of the lists returns data 0 with `resp_empty` = 1.
- R2: A push links in the address (`opa` + `opb`) modulo 2^ADDR_W. Its done response shows that address on `resp_data`, with `resp_empty` = 0. The `op` bit is 0 for a push and 1 for a pop.
- R3: A pop returns the address most recently pushed to the same list and still present there (LIFO order). The head then moves to the next older address.
- R4: The `list` field of the command selects one of NUM_LISTS (8) lists. A command leaves every other list unchanged.
- R5: A pop from an empty list returns 0 with `resp_empty` = 1, and the list stays empty.
- R6: A push whose operand sum is 0 leaves its list unchanged. Its response is data 0 with `resp_empty` = 0.
- R7: When both requesters present `valid` in the same idle cycle, requester 0 is accepted first. Requester 1 is accepted in a later command slot.
- R8: `done` is a single-cycle pulse two clock cycles after the acceptance edge. `resp_req` gives the index of the requester that issued the command.
- R9: While a command is in progress, both `ready` outputs stay low, even if `valid` is high.
- R10: A stream of mixed pushes and pops from both requesters gives results equal to running the commands one at a time, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | NUM_REQ | Command valid, one bit per requester |
| req_ready | output | NUM_REQ | Command accepted at this edge, one bit per requester |
| req_op | input | NUM_REQ | Operation per requester: 0 = push, 1 = pop |
| req_list | input | NUM_REQ*LIST_W | List number per requester (requester i in slice i) |
| req_opa | input | NUM_REQ*ADDR_W | First push operand per requester |
| req_opb | input | NUM_REQ*ADDR_W | Second push operand per requester |
| done | output | 1 | One-cycle completion pulse |
| resp_req | output | REQ_W | Index of the requester whose command completed |
| resp_data | output | ADDR_W | Pushed address, or popped head (0 when empty) |
| resp_empty | output | 1 | Pop found the list empty |

## Verification
The hardest situation to reach is two requesters competing for one list. Both commands must land in the same cycle, and the engine is busy exactly when the loser is waiting. The bench raises both `valid` lines on the same falling edge. It samples `ready` in the busy cycle, then pops the list to show that the loser's push was applied last. A long interleaved stream from both requesters then hits lists shared by both and lists used by one. Each result is compared against a per-list queue model that is updated in acceptance order.

// File: rtl/buflist_pkg.sv
package buflist_pkg;
  typedef enum logic {
    OP_PUSH = 1'b0,
    OP_POP  = 1'b1
  } op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EXEC = 1'b1
  } state_e;
endpackage

// File: rtl/buflist_arb.sv
module buflist_arb #(
  parameter int NUM_REQ = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [NUM_REQ-1:0] valid,
  output logic [NUM_REQ-1:0] grant
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (enable && valid[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_req0_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && valid[0]) |-> grant[0]);
endmodule

// File: rtl/buflist_heads.sv
module buflist_heads #(
  parameter int NUM_LISTS = 8,
  parameter int ADDR_W    = 8,
  localparam int LIST_W   = $clog2(NUM_LISTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LIST_W-1:0] sel,
  output logic [ADDR_W-1:0] head,
  input  logic              we,
  input  logic [ADDR_W-1:0] wdata
);
  logic [ADDR_W-1:0] heads_q [NUM_LISTS];

  assign head = heads_q[sel];

  generate
    for (genvar g = 0; g < NUM_LISTS; g++) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 heads_q[g] <= '0;
        else if (we && (sel == LIST_W'(g)))         heads_q[g] <= wdata;
      end
    end
  endgenerate
endmodule

// File: rtl/buflist_ram.sv
module buflist_ram #(
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W-1:0] rdata,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [ADDR_W-1:0] wdata
);
  logic [ADDR_W-1:0] mem [DEPTH];

  assign rdata = mem[raddr];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end
endmodule

// File: rtl/buflist_engine.sv
module buflist_engine
  import buflist_pkg::*;
#(
  parameter int NUM_REQ   = 2,
  parameter int NUM_LISTS = 8,
  parameter int ADDR_W    = 8,
  localparam int LIST_W   = $clog2(NUM_LISTS),
  localparam int REQ_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REQ-1:0]        req_valid,
  output logic [NUM_REQ-1:0]        req_ready,
  input  logic [NUM_REQ-1:0]        req_op,
  input  logic [NUM_REQ*LIST_W-1:0] req_list,
  input  logic [NUM_REQ*ADDR_W-1:0] req_opa,
  input  logic [NUM_REQ*ADDR_W-1:0] req_opb,
  output logic                      done,
  output logic [REQ_W-1:0]          resp_req,
  output logic [ADDR_W-1:0]         resp_data,
  output logic                      resp_empty
);
  state_e            state_q;
  op_e               op_q;
  logic [LIST_W-1:0] list_q;
  logic [ADDR_W-1:0] addr_q;
  logic [REQ_W-1:0]  who_q;

  logic [NUM_REQ-1:0] grant;
  logic               accept;
  logic               win_op;
  logic [LIST_W-1:0]  win_list;
  logic [ADDR_W-1:0]  win_addr;
  logic [REQ_W-1:0]   win_idx;

  logic [ADDR_W-1:0] cur_head, link;
  logic              head_we, ram_we;
  logic [ADDR_W-1:0] head_wdata;
  logic [ADDR_W-1:0] res_data;
  logic              res_empty;

  buflist_arb #(.NUM_REQ(NUM_REQ)) u_arb (
    .clk(clk), .rst_n(rst_n), .enable(state_q == ST_IDLE),
    .valid(req_valid), .grant(grant)
  );

  assign req_ready = grant;
  assign accept    = |grant;

  always_comb begin
    win_op   = 1'b0;
    win_list = '0;
    win_addr = '0;
    win_idx  = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (grant[i]) begin
        win_op   = req_op[i];
        win_list = req_list[i*LIST_W +: LIST_W];
        win_addr = req_opa[i*ADDR_W +: ADDR_W] + req_opb[i*ADDR_W +: ADDR_W];
        win_idx  = REQ_W'(i);
      end
    end
  end

  buflist_heads #(.NUM_LISTS(NUM_LISTS), .ADDR_W(ADDR_W)) u_heads (
    .clk(clk), .rst_n(rst_n), .sel(list_q), .head(cur_head),
    .we(head_we), .wdata(head_wdata)
  );

  buflist_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .raddr(cur_head), .rdata(link),
    .we(ram_we), .waddr(addr_q), .wdata(cur_head)
  );

  always_comb begin
    head_we    = 1'b0;
    ram_we     = 1'b0;
    head_wdata = '0;
    res_data   = '0;
    res_empty  = 1'b0;
    if (state_q == ST_EXEC) begin
      if (op_q == OP_PUSH) begin
        res_data = addr_q;
        if (addr_q != '0) begin
          ram_we     = 1'b1;
          head_we    = 1'b1;
          head_wdata = addr_q;
        end
      end else if (cur_head == '0) begin
        res_empty = 1'b1;
      end else begin
        res_data   = cur_head;
        head_we    = 1'b1;
        head_wdata = link;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      op_q       <= OP_PUSH;
      list_q     <= '0;
      addr_q     <= '0;
      who_q      <= '0;
      done       <= 1'b0;
      resp_req   <= '0;
      resp_data  <= '0;
      resp_empty <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (accept) begin
          state_q <= ST_EXEC;
          op_q    <= op_e'(win_op);
          list_q  <= win_list;
          addr_q  <= win_addr;
          who_q   <= win_idx;
        end
      end else begin
        state_q    <= ST_IDLE;
        done       <= 1'b1;
        resp_req   <= who_q;
        resp_data  <= res_data;
        resp_empty <= res_empty;
      end
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(state_q) == ST_EXEC);
  assert_busy_no_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXEC) |-> (req_ready == '0));
  assert_empty_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && resp_empty) |-> (resp_data == '0));
  assert_zero_push_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXEC && op_q == OP_PUSH && addr_q == '0) |=> $stable(cur_head));
endmodule

// File: tb/buflist_engine_bench.sv
module buflist_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;
  localparam int AW = 8;
  localparam int LW = 3;

  typedef struct {
    int  who;
    int  data;
    bit  empty;
    int  t;
    string tag;
  } exp_t;

  logic clk = 0;
  logic rst_n = 0;
  logic v0 = 0, v1 = 0, o0 = 0, o1 = 0;
  logic [LW-1:0] l0 = 0, l1 = 0;
  logic [AW-1:0] a0 = 0, a1 = 0, b0 = 0, b1 = 0;
  logic [1:0] req_ready;
  logic done, resp_req, resp_empty;
  logic [AW-1:0] resp_data;

  int errors = 0, checks = 0, ncyc = 0, next_addr = 140;
  int model [NL][$];
  exp_t expq [$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) ncyc <= ncyc + 1;

  buflist_engine u_buflist_engine (
    .clk(clk), .rst_n(rst_n), .req_valid({v1, v0}), .req_ready(req_ready),
    .req_op({o1, o0}), .req_list({l1, l0}), .req_opa({a1, a0}), .req_opb({b1, b0}),
    .done(done), .resp_req(resp_req), .resp_data(resp_data), .resp_empty(resp_empty)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(int r, bit pop, int lst, int a, int b, string tag);
    exp_t e;
    int addr;
    if (r == 0) begin v0 = 1; o0 = pop; l0 = LW'(lst); a0 = AW'(a); b0 = AW'(b); end
    else        begin v1 = 1; o1 = pop; l1 = LW'(lst); a1 = AW'(a); b1 = AW'(b); end
    forever begin
      #1;
      if (req_ready[r]) break;
      @(negedge clk);
    end
    e.t = ncyc;
    e.who = r;
    e.tag = tag;
    @(posedge clk);
    addr = (a + b) % 256;
    if (!pop) begin
      e.data = addr; e.empty = 0;
      if (addr != 0) model[lst].push_front(addr);
    end else if (model[lst].size() == 0) begin
      e.data = 0; e.empty = 1;
    end else begin
      e.data = model[lst].pop_front(); e.empty = 0;
    end
    expq.push_back(e);
    @(negedge clk);
    if (r == 0) v0 = 0; else v1 = 0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n && done) begin
      if (expq.size() == 0) check(0, "R8 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = expq.pop_front();
        check(resp_data == AW'(e.data), {e.tag, " data"}, resp_data, e.data);
        check(resp_empty == e.empty, {e.tag, " empty"}, resp_empty, e.empty);
        check(resp_req == e.who[0], "R8 resp_req", resp_req, e.who);
        check(ncyc == e.t + 2, "R8 done timing", ncyc, e.t + 2);
      end
    end
  end

  task automatic drain();
    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R8 pending responses", expq.size(), 0);
  endtask

  task automatic stream(int r);
    for (int k = 0; k < 40; k++) begin
      int lst;
      lst = (k % 2 == 0) ? (4 + k % 4) : (r * 2 + k % 2);
      if (k % 3 != 2) begin
        int ad;
        ad = next_addr;
        next_addr++;
        issue(r, 0, lst, ad - 3, 3, "R10 push");
      end else begin
        issue(r, 1, lst, 0, 0, "R10 pop");
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(done == 0, "R1 done after reset", done, 0);
    check(req_ready == 0, "R1 ready idle", req_ready, 0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NL; i++) issue(0, 1, i, 0, 0, "R1 empty pop");
    drain();
    issue(0, 0, 2, 10, 5, "R2 push");
    issue(0, 0, 2, 100, 1, "R2 push");
    issue(1, 0, 2, 200, 100, "R2 wrap push");
    issue(0, 1, 2, 0, 0, "R3 pop");
    issue(1, 1, 2, 0, 0, "R3 pop");
    issue(0, 1, 2, 0, 0, "R3 pop");
    issue(0, 1, 2, 0, 0, "R5 empty pop");
    issue(0, 1, 2, 0, 0, "R5 empty pop again");
    issue(0, 0, 2, 7, 0, "R5 push after empty");
    issue(0, 1, 2, 0, 0, "R5 pop after empty");
    issue(0, 0, 0, 20, 0, "R4 push");
    issue(0, 0, 7, 30, 0, "R4 push");
    issue(0, 1, 0, 0, 0, "R4 pop");
    issue(0, 1, 7, 0, 0, "R4 pop");
    issue(0, 0, 3, 50, 0, "R6 push");
    issue(0, 0, 3, 0, 0, "R6 zero push");
    issue(1, 0, 3, 128, 128, "R6 zero sum push");
    issue(0, 1, 3, 0, 0, "R6 pop");
    issue(0, 1, 3, 0, 0, "R6 pop empty");
    drain();
    fork
      issue(1, 0, 4, 60, 0, "R7 loser push");
      issue(0, 0, 4, 61, 0, "R7 winner push");
      begin
        @(posedge clk);
        #2;
        check(req_ready == 2'b00, "R9 ready while busy", req_ready, 0);
      end
    join
    issue(1, 1, 4, 0, 0, "R7 pop sees loser last");
    issue(1, 1, 4, 0, 0, "R7 pop sees winner");
    drain();
    fork
      stream(0);
      stream(1);
    join
    drain();
    for (int i = 0; i < NL; i++) begin
      while (model[i].size() > 0) issue(0, 1, i, 0, 0, "R10 final pop");
      issue(0, 1, i, 0, 0, "R10 final empty");
    end
    drain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule